// File: doc/BRIEF.md
# Three-Bit Serial Frame Receiver with Status Flags

This block receives short frames from a serial line that shares its clock with the sender, so one bit lasts exactly one clock cycle. While idle it treats a high line as the start of a frame. It samples the next `DATA_BITS` cycles as data, least significant bit first, and then checks the cycle that follows as the stop slot. Each received bit goes into its own JK-style flip-flop, and the state machine drives the J and K controls of that flip-flop. The bits appear in parallel on `rx_data`.

A correct stop bit (low) raises `ok_flag`. The flag stays up until the consumer pulls the active-low acknowledge, or until the next frame starts. A wrong stop bit (high) raises `err_flag`. That flag stays up for as long as the line stays high. While it is up, the receiver does not take a high line as a new start bit. The cycle in which the line is sampled low clears the error and returns the receiver to idle. That low cycle is not itself a start.

Top module: `frame_rx`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `rx_data` = 0, `ok_flag` = 0 and `err_flag` = 0.
- R2: In idle, a 1 sampled on `ser_in` is the start bit. The line values sampled in the following `DATA_BITS` cycles are stored in `rx_data[0]`, `rx_data[1]`, ... in that order. Each bit appears one cycle after it is sampled.
- R3: `rx_data` keeps its value after a frame ends, and changes only while a later frame overwrites it.
- R4: A 0 sampled in the stop slot (the cycle after the last data bit) sets `ok_flag` in the next cycle.
- R5: `ok_flag` stays high until a cycle samples `ack_n` = 0 or a new start bit. It is low in the cycle after that sample.
- R6: A 1 sampled in the stop slot sets `err_flag` in the next cycle and leaves `ok_flag` low.
- R7: `err_flag` stays high while `ser_in` is sampled 1 and falls one cycle after `ser_in` is sampled 0. `ack_n` has no effect on it.
- R8: While `err_flag` is high, a high `ser_in` does not start a frame. The cycle that clears the error is not a start either, so `rx_data` is unchanged through the error period.
- R9: `ok_flag` and `err_flag` are never high together.
- R10: `ack_n` has no effect while a frame is being received or while `ok_flag` is low. Captured data and the frame outcome stay the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the sender; one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial line |
| ack_n | input | 1 | Active-low acknowledge that clears `ok_flag` |
| rx_data | output | DATA_BITS | Received data bits, bit 0 first on the line |
| ok_flag | output | 1 | Frame received with a valid stop bit |
| err_flag | output | 1 | Frame received with a high stop bit; held while the line stays high |

## Verification
The bench sends frames back to back, with the next start bit in the cycle right after the stop slot. A receiver that needs an idle gap would drop that frame or leave `ok_flag` set. The bench holds the line high for several cycles after a bad stop bit. A design that re-arms on that level would start a false frame and corrupt `rx_data`, and one that ignores the line would drop the error early. The bench also drives acknowledge pulses during frames, during errors and with no frame pending, and it raises acknowledge and a start bit in the same cycle. A wrong priority there shows up as a stray or missing `ok_flag`. Long stretches of random line and acknowledge activity are compared cycle by cycle against a behavioural model.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_BITS  = 2'd1,
    RX_STOP  = 2'd2,
    RX_ERRW  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int DATA_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_in,
  input  logic                 ack_n,
  output logic [DATA_BITS-1:0] jk_j,
  output logic [DATA_BITS-1:0] jk_k,
  output logic                 ok_set,
  output logic                 ok_clr,
  output logic                 err_set,
  output logic                 err_clr
);
  localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_BITS - 1);

  rx_state_t        state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [DATA_BITS-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sel     = '0;
    ok_set  = 1'b0;
    ok_clr  = 1'b0;
    err_set = 1'b0;
    err_clr = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (ser_in) begin
          state_d = RX_BITS;
          idx_d   = '0;
          ok_clr  = 1'b1;
        end else if (!ack_n) begin
          ok_clr = 1'b1;
        end
      end
      RX_BITS: begin
        sel[idx_q] = 1'b1;
        if (idx_q == LAST_IDX) begin
          state_d = RX_STOP;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (ser_in) begin
          err_set = 1'b1;
          state_d = RX_ERRW;
        end else begin
          ok_set  = 1'b1;
          state_d = RX_IDLE;
        end
      end
      RX_ERRW: begin
        if (!ser_in) begin
          err_clr = 1'b1;
          state_d = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  generate
    for (genvar g = 0; g < DATA_BITS; g++) begin : g_jk
      assign jk_j[g] = sel[g] & ser_in;
      assign jk_k[g] = sel[g] & ~ser_in;
    end
  endgenerate
endmodule

// File: rtl/frame_rx_jk_bank.sv
module frame_rx_jk_bank #(
  parameter int DATA_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] j_in,
  input  logic [DATA_BITS-1:0] k_in,
  output logic [DATA_BITS-1:0] q_out
);
  generate
    for (genvar g = 0; g < DATA_BITS; g++) begin : g_ff
      always_ff @(posedge clk) begin
        if (rst) q_out[g] <= 1'b0;
        else     q_out[g] <= (j_in[g] & ~q_out[g]) | (~k_in[g] & q_out[g]);
      end
    end
  endgenerate
endmodule

// File: rtl/frame_rx_flags.sv
module frame_rx_flags (
  input  logic clk,
  input  logic rst,
  input  logic ok_set,
  input  logic ok_clr,
  input  logic err_set,
  input  logic err_clr,
  output logic ok_q,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ok_set)       ok_q <= 1'b1;
      else if (ok_clr)  ok_q <= 1'b0;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int DATA_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_in,
  input  logic                 ack_n,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 ok_flag,
  output logic                 err_flag
);
  logic [DATA_BITS-1:0] jk_j, jk_k;
  logic ok_set, ok_clr, err_set, err_clr;

  frame_rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ack_n(ack_n),
    .jk_j(jk_j), .jk_k(jk_k),
    .ok_set(ok_set), .ok_clr(ok_clr), .err_set(err_set), .err_clr(err_clr)
  );

  frame_rx_jk_bank #(.DATA_BITS(DATA_BITS)) u_bank (
    .clk(clk), .rst(rst), .j_in(jk_j), .k_in(jk_k), .q_out(rx_data)
  );

  frame_rx_flags u_flags (
    .clk(clk), .rst(rst),
    .ok_set(ok_set), .ok_clr(ok_clr), .err_set(err_set), .err_clr(err_clr),
    .ok_q(ok_flag), .err_q(err_flag)
  );
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
  parameter int DATA_BITS = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ser_in,
  input logic                 ack_n,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 ok_flag,
  input logic                 err_flag
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rx_data == '0 && !ok_flag && !err_flag));
  // R9
  flag_mutex_chk: assert property (@(posedge clk) disable iff (rst)
    !(ok_flag && err_flag));
  // R5
  ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_flag && ack_n && !ser_in) |=> ok_flag);
  // R5
  ok_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_flag && !ack_n) |=> !ok_flag);
  // R5
  ok_newframe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_flag && ser_in) |=> !ok_flag);
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && ser_in) |=> err_flag);
  // R7
  err_release_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !ser_in) |=> !err_flag);
  // R8
  err_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> $stable(rx_data));
endmodule

bind frame_rx frame_rx_chk #(.DATA_BITS(DATA_BITS)) u_frame_rx_chk (
  .clk(clk), .rst(rst), .ser_in(ser_in), .ack_n(ack_n),
  .rx_data(rx_data), .ok_flag(ok_flag), .err_flag(err_flag)
);

// File: tb/frame_rx_bench.sv
module frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic ack_n = 1'b1;
  logic [NB-1:0] rx_data;
  logic ok_flag, err_flag;

  int checks = 0;
  int fails = 0;

  // behavioural model
  int  m_phase = 0;   // 0 idle, 1 data, 2 stop, 3 waiting for low line
  int  m_left = 0;
  bit  m_bits[$];
  logic [NB-1:0] e_data = '0;
  logic e_ok = 1'b0, e_err = 1'b0;

  frame_rx #(.DATA_BITS(NB)) u_frame_rx (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ack_n(ack_n),
    .rx_data(rx_data), .ok_flag(ok_flag), .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_bits.delete(); e_data = '0; e_ok = 0; e_err = 0;
    end else begin
      case (m_phase)
        0: if (ser_in) begin
             e_ok = 0; m_phase = 1; m_left = NB; m_bits.delete();
           end else if (!ack_n) e_ok = 0;
        1: begin
             m_bits.push_back(ser_in);
             e_data[m_bits.size()-1] = ser_in;
             m_left--;
             if (m_left == 0) m_phase = 2;
           end
        2: if (ser_in) begin e_err = 1; m_phase = 3; end
           else begin e_ok = 1; m_phase = 0; end
        default: if (!ser_in) begin e_err = 0; m_phase = 0; end
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 R3 data", rx_data, e_data);
      check("R4 R5 ok", ok_flag, e_ok);
      check("R6 R7 err", err_flag, e_err);
      check("R9 mutex", ok_flag & err_flag, 0);
    end
  end

  task automatic drive(input logic s, input logic a);
    @(negedge clk);
    ser_in = s; ack_n = a;
  endtask

  task automatic frame(input logic [NB-1:0] d, input logic stop, input logic a);
    drive(1'b1, a);
    for (int i = 0; i < NB; i++) drive(d[i], a);
    drive(stop, a);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", rx_data, 0);
    check("R1 ok", ok_flag, 0);
    check("R1 err", err_flag, 0);
    drive(1'b0, 1'b1);
    rst = 1'b0;
    repeat (2) drive(1'b0, 1'b1);
    // R2 R4: good frame, bits 101
    frame(3'b101, 1'b0, 1'b1);
    drive(1'b0, 1'b1);
    check("R2 value", rx_data, 5);
    check("R4 ok", ok_flag, 1);
    // R3 R5 hold while idle
    repeat (4) drive(1'b0, 1'b1);
    check("R3 hold", rx_data, 5);
    check("R5 hold", ok_flag, 1);
    // R5 ack clears
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    check("R5 ack", ok_flag, 0);
    check("R3 after ack", rx_data, 5);
    // R10 ack with no ok pending and during a frame
    drive(1'b0, 1'b0);
    frame(3'b011, 1'b0, 1'b0);
    drive(1'b0, 1'b1);
    check("R10 data", rx_data, 3);
    // ack in stop cycle sampled before ok rises; model resolves
    // R5 back-to-back frames: new start clears ok
    frame(3'b110, 1'b0, 1'b1);
    frame(3'b001, 1'b0, 1'b1);
    drive(1'b0, 1'b1);
    check("R5 back-to-back", rx_data, 1);
    check("R4 back-to-back ok", ok_flag, 1);
    // R6 R7 R8: bad stop then long high line with ack pulses
    frame(3'b010, 1'b1, 1'b1);
    drive(1'b1, 1'b0);
    check("R6 err", err_flag, 1);
    check("R6 ok low", ok_flag, 0);
    repeat (5) drive(1'b1, 1'b0);
    check("R8 no start", rx_data, 2);
    check("R7 held", err_flag, 1);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    check("R7 released", err_flag, 0);
    // line high again from idle: real start
    for (int i = 0; i < NB; i++) drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    check("R2 after error", rx_data, 7);
    check("R4 after error", ok_flag, 1);
    // random stress
    for (int i = 0; i < 3000; i++)
      drive(1'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0));
    // reset mid-activity
    drive(1'b1, 1'b1);
    rst = 1'b1;
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    check("R1 again data", rx_data, 0);
    check("R1 again flags", {ok_flag, err_flag}, 0);
    rst = 1'b0;
    repeat (3) drive(1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule